// File: doc/BRIEF.md
# Serial flash write-protection controller

This block is the gatekeeper that decides whether the status register of a serial flash device may be rewritten and whether commands that modify the memory array may proceed. It holds the protection state: a four-bit protection level, a top/bottom select bit, a lock bit that arms hardware protection, and the write-enable latch. An upstream decoder hands it one decoded command at a time, with a byte address and a data byte. The block answers one clock later with either an accept pulse or a reject pulse.

The protection level names a range of 64 KiB sectors of a 32 MiB array, taken from the top or the bottom end. Program and erase commands that touch that range are refused. The active-low write-protect pin passes through a two-flop synchronizer. When the synchronized pin is low and the lock bit is set, the block is in hardware-protected mode: the status register is frozen until the pin goes high again. A status-register write is only honoured when a write-enable command has set the latch beforehand. Any write or erase command clears the latch, whether it is accepted or refused.

Top module: `sfwp_ctrl`

## Requirements
- R1: After reset, status_o is 0, hpm_o is 0, and accept_o and reject_o are both 0.
- R2: Command codes on cmd_op_i are: 0 none, 1 write-enable, 2 status write, 3 program (covering all program variants), 4 4 KiB subsector erase, 5 64 KiB sector erase, 6 bulk erase. The status_o layout is: bits 3:0 level, bit 4 top/bottom select, bit 5 lock, bit 6 write-enable latch, bit 7 always 0. A write-enable command is always accepted and sets bit 6.
- R3: A status write issued while the latch is 0 is rejected, and status_o stays unchanged.
- R4: When lock is 1 and the synchronized pin is 0, hpm_o is 1. This holds whichever of the two became true first. While hpm_o is 1, every status write is rejected, even with the latch set, and level, select and lock keep their values.
- R5: The pin passes through two flip-flops. hpm_o reflects a pin change after the second rising clock edge, and not after the first. Only driving the pin high clears hpm_o. While the pin is high, hpm_o stays 0.
- R6: An accepted status write loads level from data bits 3:0, select from data bit 4 and lock from data bit 5. Data bits 7:6 are ignored.
- R7: Level 0 protects nothing. A level n from 1 to 9 protects 2^(n-1) sectors, where the sector index is address bits 24:16. With select 0 these are the highest sector indices; with select 1 they are the lowest. Levels 10 to 15 protect all 512 sectors.
- R8: With the latch set, program, subsector erase and sector erase are rejected when the addressed sector is protected, and accepted otherwise.
- R9: With the latch set, bulk erase is accepted only when the level is 0.
- R10: Every status write, program, subsector erase or sector erase command clears the latch, whether it is accepted or rejected. Bulk erase does the same. Without the latch, each of these commands is rejected.
- R11: accept_o and reject_o are single-cycle pulses, asserted in the cycle after the command and never together. A rejected command leaves bits 5:0 of status_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Asynchronous active-low write-protect pin |
| cmd_valid_i | input | 1 | A decoded command is present this cycle |
| cmd_op_i | input | 3 | Command code |
| cmd_addr_i | input | 25 | Target byte address |
| cmd_data_i | input | 8 | Status write data |
| accept_o | output | 1 | Command accepted pulse |
| reject_o | output | 1 | Command rejected pulse |
| status_o | output | 8 | Protection status bits |
| hpm_o | output | 1 | Hardware-protected mode active |

## Verification
The assertions assume that cmd_op_i carries one of the listed codes whenever cmd_valid_i is high. They also assume that the address and data inputs are valid in the same cycle. The stimulus draws commands only from the defined codes. It changes the write-protect pin only between commands and waits three cycles before issuing the next one, so each command sees a settled synchronized pin. The bench model can therefore treat the pin as a plain level.

// File: rtl/sfwp_pkg.sv
package sfwp_pkg;
  localparam int LVL_W  = 4;
  localparam int DATA_W = 8;
  localparam int STAT_W = 8;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WREN = 3'd1,
    OP_WRSR = 3'd2,
    OP_PROG = 3'd3,
    OP_SSE  = 3'd4,
    OP_SE   = 3'd5,
    OP_BE   = 3'd6
  } op_e;
endpackage

// File: rtl/sfwp_sync.sv
module sfwp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sfwp_range.sv
module sfwp_range #(
  parameter int ADDR_W = 25,
  parameter int SECT_W = 16,
  parameter int LVL_W  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              tb_i,
  output logic              in_prot_o,
  output logic              any_prot_o
);
  localparam int IDX_W = ADDR_W - SECT_W;
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] TOTAL = CNT_W'(1) << IDX_W;

  logic [CNT_W-1:0] sect;
  logic [CNT_W-1:0] count;
  logic             full;

  always_comb begin
    sect  = {1'b0, addr_i[ADDR_W-1:SECT_W]};
    full  = (32'(lvl_i) > IDX_W);
    count = '0;
    if (full)              count = TOTAL;
    else if (lvl_i != '0)  count = CNT_W'(1) << (lvl_i - LVL_W'(1));
    any_prot_o = (lvl_i != '0);
    if (!any_prot_o)  in_prot_o = 1'b0;
    else if (full)    in_prot_o = 1'b1;
    else if (tb_i)    in_prot_o = (sect < count);
    else              in_prot_o = (sect >= (TOTAL - count));
  end

  always_comb begin
    assert (!in_prot_o || any_prot_o); // R7: protection implies nonzero level
  end
endmodule

// File: rtl/sfwp_status.sv
module sfwp_status
  import sfwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              wp_s_i,
  input  logic              in_prot_i,
  input  logic              any_prot_i,
  output logic              accept_o,
  output logic              reject_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              tb_o,
  output logic              lock_o,
  output logic              wel_o,
  output logic              hpm_o
);
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic tb_q, tb_d, lock_q, lock_d, wel_q, wel_d;
  logic acc_q, acc_d, rej_q, rej_d;
  logic hpm;
  logic grant;

  assign hpm = lock_q & ~wp_s_i;

  always_comb begin
    lvl_d  = lvl_q;
    tb_d   = tb_q;
    lock_d = lock_q;
    wel_d  = wel_q;
    acc_d  = 1'b0;
    rej_d  = 1'b0;
    grant  = 1'b0;
    if (cmd_valid_i) begin
      case (op_e'(cmd_op_i))
        OP_WREN: begin
          wel_d = 1'b1;
          acc_d = 1'b1;
        end
        OP_WRSR: begin
          grant = wel_q & ~hpm;
          if (grant) begin
            lvl_d  = cmd_data_i[LVL_W-1:0];
            tb_d   = cmd_data_i[LVL_W];
            lock_d = cmd_data_i[LVL_W+1];
          end
          acc_d = grant;
          rej_d = ~grant;
          wel_d = 1'b0;
        end
        OP_PROG, OP_SSE, OP_SE: begin
          grant = wel_q & ~in_prot_i;
          acc_d = grant;
          rej_d = ~grant;
          wel_d = 1'b0;
        end
        OP_BE: begin
          grant = wel_q & ~any_prot_i;
          acc_d = grant;
          rej_d = ~grant;
          wel_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      tb_q   <= 1'b0;
      lock_q <= 1'b0;
      wel_q  <= 1'b0;
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      tb_q   <= tb_d;
      lock_q <= lock_d;
      wel_q  <= wel_d;
      acc_q  <= acc_d;
      rej_q  <= rej_d;
    end
  end

  assign accept_o = acc_q;
  assign reject_o = rej_q;
  assign lvl_o    = lvl_q;
  assign tb_o     = tb_q;
  assign lock_o   = lock_q;
  assign wel_o    = wel_q;
  assign hpm_o    = hpm;

  a_r11_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept_o, reject_o}));

  a_r3_wrsr_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_WRSR && !wel_o) |=> (reject_o && $stable({lock_o, tb_o, lvl_o})));

  a_r4_hpm_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_WRSR && hpm_o) |=> (reject_o && $stable({lock_o, tb_o, lvl_o})));

  a_r10_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i >= OP_WRSR && cmd_op_i <= OP_BE) |=> !wel_o);

  a_r9_bulk_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_BE && lvl_o != '0) |=> reject_o);

  a_r11_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> $stable({lock_o, tb_o, lvl_o}));

  a_r5_pin_high_no_hpm: assert property (@(posedge clk) disable iff (!rst_n)
    wp_s_i |-> !hpm_o);
endmodule

// File: rtl/sfwp_ctrl.sv
module sfwp_ctrl
  import sfwp_pkg::*;
#(
  parameter int ADDR_W      = 25,
  parameter int SECT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              accept_o,
  output logic              reject_o,
  output logic [STAT_W-1:0] status_o,
  output logic              hpm_o
);
  logic             wp_s;
  logic             in_prot, any_prot;
  logic [LVL_W-1:0] lvl;
  logic             tb, lock, wel;

  sfwp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(wp_n_i), .q_o(wp_s)
  );

  sfwp_range #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .LVL_W(LVL_W)) u_range (
    .addr_i(cmd_addr_i), .lvl_i(lvl), .tb_i(tb),
    .in_prot_o(in_prot), .any_prot_o(any_prot)
  );

  sfwp_status u_status (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_data_i(cmd_data_i),
    .wp_s_i(wp_s), .in_prot_i(in_prot), .any_prot_i(any_prot),
    .accept_o(accept_o), .reject_o(reject_o),
    .lvl_o(lvl), .tb_o(tb), .lock_o(lock), .wel_o(wel), .hpm_o(hpm_o)
  );

  assign status_o = {1'b0, wel, lock, tb, lvl};
endmodule

// File: tb/sfwp_ctrl_bench.sv
module sfwp_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [24:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic accept, reject, hpm;
  logic [7:0] status;

  int tests = 0;
  int fails = 0;

  logic [3:0] m_lvl;
  logic m_tb, m_lock, m_wel, m_pin;

  always #5 clk = ~clk;

  sfwp_ctrl u_sfwp_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .cmd_data_i(cmd_data),
    .accept_o(accept), .reject_o(reject), .status_o(status), .hpm_o(hpm)
  );

  function automatic bit prot(input logic [3:0] lvl, input logic tb, input logic [24:0] a);
    int sect = int'(a[24:16]);
    int cnt;
    if (lvl == 0) return 0;
    cnt = (lvl >= 10) ? 512 : (1 << (lvl - 1));
    if (tb) return sect < cnt;
    return sect >= 512 - cnt;
  endfunction

  function automatic logic [7:0] exp_status();
    return {1'b0, m_wel, m_lock, m_tb, m_lvl};
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got acc/rej/status/hpm %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [24:0] a, input logic [7:0] d, input string req);
    logic ea, er;
    bit hp;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    ea = 0; er = 0;
    hp = m_lock && !m_pin;
    case (op)
      3'd1: begin ea = 1; m_wel = 1; end
      3'd2: begin
        ea = m_wel && !hp; er = !ea;
        if (ea) begin m_lvl = d[3:0]; m_tb = d[4]; m_lock = d[5]; end
        m_wel = 0;
      end
      3'd3, 3'd4, 3'd5: begin ea = m_wel && !prot(m_lvl, m_tb, a); er = !ea; m_wel = 0; end
      3'd6: begin ea = m_wel && (m_lvl == 0); er = !ea; m_wel = 0; end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    check(req, {accept, reject, status, hpm},
          {ea, er, exp_status(), m_lock && !m_pin});
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); wp_n = v;
    repeat (3) @(negedge clk);
    m_pin = v;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_lvl = 0; m_tb = 0; m_lock = 0; m_wel = 0; m_pin = 1;
    repeat (3) @(negedge clk);
    check("R1 reset", {accept, reject, status, hpm}, 11'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {accept, reject, status, hpm}, 11'd0);

    issue(3'd2, 0, 8'h0F, "R3 status write without latch");
    issue(3'd1, 0, 0, "R2 write-enable");
    issue(3'd2, 0, 8'hE3, "R6 status write, top bits ignored");
    @(negedge clk);
    check("R11 pulse lasts one cycle", {accept, reject}, 2'b00);
    issue(3'd3, 25'h0, 0, "R10 program without latch");

    // R5: pin goes low with lock set; two edges needed
    @(negedge clk); wp_n = 1'b0;
    @(negedge clk);
    check("R5 one edge, hpm not yet", {10'd0, hpm}, 11'd0);
    @(negedge clk);
    check("R5/R4 two edges, hpm set", {10'd0, hpm}, 11'd1);
    @(negedge clk); m_pin = 0;
    issue(3'd1, 0, 0, "R2 write-enable in hpm");
    issue(3'd2, 0, 8'h00, "R4 status write blocked in hpm");
    set_pin(1'b1);
    check("R5 pin high clears hpm", {10'd0, hpm}, 11'd0);
    issue(3'd1, 0, 0, "R2 write-enable");
    issue(3'd2, 0, 8'h00, "R6 unlock");
    // R4 other order: pin low first, then set lock
    set_pin(1'b0);
    issue(3'd1, 0, 0, "R2 write-enable");
    issue(3'd2, 0, 8'h21, "R4 lock set with pin low");
    issue(3'd1, 0, 0, "R2 write-enable");
    issue(3'd2, 0, 8'h00, "R4 frozen after second order");
    set_pin(1'b1);
    issue(3'd1, 0, 0, "R2 write-enable");
    issue(3'd2, 0, 8'h01, "R6 level 1 top");
    issue(3'd1, 0, 0, "R2");
    issue(3'd3, 25'h1FF0000, 0, "R7 top sector protected");
    issue(3'd1, 0, 0, "R2");
    issue(3'd4, 25'h1FEFFFF, 0, "R8 sector below top free");
    issue(3'd1, 0, 0, "R2");
    issue(3'd6, 0, 0, "R9 bulk erase with protection");
    issue(3'd1, 0, 0, "R2");
    issue(3'd2, 0, 8'h11, "R6 level 1 bottom");
    issue(3'd1, 0, 0, "R2");
    issue(3'd5, 25'h000FFFF, 0, "R7 bottom sector protected");
    issue(3'd1, 0, 0, "R2");
    issue(3'd5, 25'h0010000, 0, "R8 sector 1 free");
    issue(3'd1, 0, 0, "R2");
    issue(3'd2, 0, 8'h0A, "R6 level 10");
    issue(3'd1, 0, 0, "R2");
    issue(3'd3, 25'h0000000, 0, "R7 level 10 covers all");
    issue(3'd1, 0, 0, "R2");
    issue(3'd2, 0, 8'h09, "R6 level 9");
    issue(3'd1, 0, 0, "R2");
    issue(3'd3, 25'h0FFFFFF, 0, "R7 level 9 lower half free");
    issue(3'd1, 0, 0, "R2");
    issue(3'd3, 25'h1000000, 0, "R7 level 9 upper half protected");
    issue(3'd1, 0, 0, "R2");
    issue(3'd2, 0, 8'h00, "R6 level 0");
    issue(3'd1, 0, 0, "R2");
    issue(3'd6, 0, 0, "R9 bulk erase with level 0");

    void'($urandom(32'h5EED));
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 19);
      if (r == 0) set_pin(~m_pin);
      else begin
        logic [2:0] op = (r < 7) ? 3'd1 : 3'($urandom_range(0, 6));
        logic [24:0] a = 25'($urandom);
        logic [7:0] d = 8'($urandom);
        if ($urandom_range(0, 3) == 0) d[5] = 1'b0;
        issue(op, a, d, "R8 R10 random");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule